// File: doc/BRIEF.md
# Reversible-Primitive One-Hot Select Decoder

This block turns an n-bit binary select into 2^n one-hot select lines. It is assembled only from bijective primitives, each a module of its own with as many outputs as inputs: a two-line controlled inverter and a three-line controlled exchange. No output of any primitive drives more than one load. Constant lines (a 1 on the first stage, 0 on every exchange gate) are tied inside the block.

The first stage is a single controlled inverter whose target line is held at 1. It yields the select bit and its complement as the two lines of a 1-of-2 decode. Each further select bit then drives a row of exchange gates, one per line of the previous stage. Every gate splits its incoming line into a "bit clear" half and a "bit set" half. The select bit passes from one gate to the next along the row through the control pass-through. The pass-through leaving the last gate of each row has no further use, so it leaves the block on a garbage bus of n-1 bits. The structure uses 2^n-1 primitives in total. The block is purely combinational and is used wherever a one-hot row or bank select is needed from an encoded index.

Top module: `rv_onehot_decoder`

## Requirements
- R1: For every select value s, line_o bit s is 1 and every other bit of line_o is 0 (bit i of line_o corresponds to the binary value i on sel_i).
- R2: For every select value exactly one bit of line_o is 1, and every exchange gate keeps the number of ones on its outputs equal to the number on its inputs.
- R3: junk_o bit k-1 carries the value of sel_i bit k, for k from 1 to n-1, since it is the control pass-through leaving the last exchange gate of the row driven by that select bit.
- R4: junk_o is exactly n-1 bits wide.
- R5: The outputs depend only on the present select value; applying a value after any other value (rising, falling or Gray-code order, or alternating extremes) gives the same lines as applying it first.
- R6: With all select bits above bit 0 at 0, line_o bit 0 equals the inverse of sel_i bit 0 and line_o bit 1 equals sel_i bit 0 (the first-stage inverter with its target held at 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | SEL_W | Binary select index |
| line_o | output | 2**SEL_W | One-hot select lines, bit i high when sel_i equals i |
| junk_o | output | SEL_W-1 | Garbage bus: unused control pass-through of each exchange row |

## Verification
The in-line checks assume sel_i carries a known 0/1 value. They are skipped while any select bit is unknown, so they cannot fire on an undriven input. The bench therefore starts the select at 0 from time zero and changes it only with whole, fully known values. It changes the select just after a rising clock edge and reads the lines at the falling edge, so every primitive in the chain has settled before any comparison.

// File: rtl/rv_pkg.sv
package rv_pkg;
    // Number of primitives in an n-bit decoder: one inverter plus one exchange
    // gate per line of every earlier stage.
    function automatic int gate_count(input int n);
        return (1 << n) - 1;
    endfunction

    // One unused control pass-through leaves each exchange row.
    function automatic int junk_count(input int n);
        return n - 1;
    endfunction
endpackage

// File: rtl/rv_cnot.sv
module rv_cnot (
    input  logic a,
    input  logic b,
    output logic p,
    output logic q
);
    assign p = a;
    assign q = a ^ b;

    // R2: the gate is a bijection; both inputs are recoverable from outputs.
    always_comb begin
        if (!$isunknown({a, b})) begin
            assert_cnot_invertible_R2: assert ((p == a) && ((p ^ q) == b))
                else $error("controlled inverter lost information");
        end
    end
endmodule

// File: rtl/rv_cswap.sv
module rv_cswap (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    assign p = a;
    assign q = a ? c : b;
    assign r = a ? b : c;

    // R2: the exchange gate is conservative and passes its control through.
    always_comb begin
        if (!$isunknown({a, b, c})) begin
            assert_swap_conserve_R2: assert (($countones({p, q, r}) == $countones({a, b, c})) && (p == a))
                else $error("exchange gate changed the number of ones");
        end
    end
endmodule

// File: rtl/rv_onehot_decoder.sv
module rv_onehot_decoder #(
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0]        sel_i,
    output logic [(1 << SEL_W)-1:0] line_o,
    output logic [SEL_W-2:0]        junk_o
);
    import rv_pkg::*;

    localparam int LINES  = 1 << SEL_W;
    localparam int GATES  = gate_count(SEL_W);
    localparam int JUNK_W = junk_count(SEL_W);

    initial begin
        assert_width_R4: assert (SEL_W >= 2 && $bits(junk_o) == JUNK_W && GATES == LINES - 1)
            else $error("decoder shape does not match its parameters");
    end

    for (genvar k = 0; k < SEL_W; k++) begin : g_stage
        logic [(2 << k)-1:0] lines;
        if (k == 0) begin : g_first
            // Target held at 1: p gives the select bit, q its complement.
            rv_cnot u_inv (
                .a (sel_i[0]),
                .b (1'b1),
                .p (lines[1]),
                .q (lines[0])
            );
        end else begin : g_split
            localparam int HALF = 1 << k;
            logic [HALF:0] ctl;
            assign ctl[0] = sel_i[k];
            for (genvar j = 0; j < HALF; j++) begin : g_gate
                rv_cswap u_sw (
                    .a (ctl[j]),
                    .b (g_stage[k-1].lines[j]),
                    .c (1'b0),
                    .p (ctl[j+1]),
                    .q (lines[j]),
                    .r (lines[j+HALF])
                );
            end
            assign junk_o[k-1] = ctl[HALF];
        end
    end

    assign line_o = g_stage[SEL_W-1].lines;

    always_comb begin
        if (!$isunknown(sel_i)) begin
            assert_onehot_R2: assert ($onehot(line_o))
                else $error("select lines not one-hot");
            assert_index_R1: assert (line_o[sel_i] == 1'b1)
                else $error("wrong select line raised");
            assert_junk_R3: assert (junk_o == sel_i[SEL_W-1:1])
                else $error("garbage bus does not follow select");
        end
    end
endmodule

// File: tb/test_rv_onehot_decoder.sv
module test_rv_onehot_decoder;
    localparam int N     = 3;
    localparam int LINES = 1 << N;

    logic             clk   = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     sel   = '0;
    logic [LINES-1:0] line_o;
    logic [N-2:0]     junk_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    rv_onehot_decoder #(.SEL_W(N)) i_rv_onehot_decoder (
        .sel_i  (sel),
        .line_o (line_o),
        .junk_o (junk_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural model: a queue of expected select values, one per cycle.
    task automatic apply(input int v, input string req);
        @(posedge clk);
        sel <= v[N-1:0];
        exp_q.push_back(v);
        @(negedge clk);
        begin
            int e = exp_q.pop_front();
            int ones = 0;
            for (int i = 0; i < LINES; i++) ones += int'(line_o[i]);
            check({req, " R1 line"}, line_o, longint'(1) << e);
            check({req, " R2 ones"}, ones, 1);
            check({req, " R3 junk"}, junk_o, e >> 1);
            if (e < 2) begin
                check({req, " R6 lo"}, line_o[0], (e == 0) ? 1 : 0);
                check({req, " R6 hi"}, line_o[1], e);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        check("reset R1", line_o, 1);
        check("width R4", $bits(junk_o), N - 1);
        for (int v = 0; v < LINES; v++) apply(v, "rising");
        for (int v = LINES - 1; v >= 0; v--) apply(v, "falling R5");
        for (int v = 0; v < LINES; v++) apply(v ^ (v >> 1), "gray R5");
        for (int t = 0; t < 4; t++) begin
            apply(0, "alt R5");
            apply(LINES - 1, "alt R5");
        end
        apply(1, "first stage R6");
        apply(0, "first stage R6");
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule